// File: doc/BRIEF.md
# Cascadable Pulse Accumulator

This block counts activity on one external input. It holds two byte-wide counters. They either run as a single 16-bit accumulator, with the low byte carrying into the high byte, or as two independent byte counters. Both counters see the same count events.

In event mode the block counts active edges of the input. In gated mode it counts pulses of a prescaled clock enable while the input is held at its active level. The input passes through a two-flop synchroniser before any edge is detected.

A simple strobe bus gives access to four registers: control, flags, count high byte and count low byte. A wide access to the high-byte address moves both count bytes in one cycle. The flag register holds:
- an overflow flag, set when the high byte wraps;
- an input-edge flag, set by an active edge in event mode and by the trailing gate edge in gated mode.

An interrupt request is raised from the flags through per-flag enables. An optional fast-clear mode clears every flag on any count register access.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register, the flags, both count bytes and `irq` are all zero.
- R2: In event mode (control bit 1 = 0), each active edge of `pin_in` adds one to the count. The active edge is rising when control bit 2 = 1 and falling when it is 0. The opposite edge adds nothing. The count changes on the third rising clock edge after the pin changes.
- R3: In gated mode (control bit 1 = 1), the count adds one for each cycle with `tick_en` = 1 while the synchronised pin is at its active level (high when control bit 2 = 1, low when 0). With the gate inactive, `tick_en` adds nothing.
- R4: With control bit 0 = 1, the two bytes form one 16-bit counter: the high byte advances when a count step wraps the low byte from 0xFF to 0x00.
- R5: With control bit 0 = 0, each count event advances the high byte and the low byte independently, with no carry between them.
- R6: The overflow flag (flag register bit 1) is set when a count step wraps the high byte from 0xFF to 0x00.
- R7: The input-edge flag (flag register bit 0) is set by each active edge in event mode. In gated mode it is set by the trailing edge of the gate (active level to inactive level), and not by its leading edge.
- R8: Writing the flag register (address 1) clears each flag whose data bit is 1 and leaves flags whose data bit is 0. A flag set event in the same cycle as its clear leaves the flag set.
- R9: With control bit 3 = 1, any read or write of address 2 or 3 clears both flags. With control bit 3 = 0, count register accesses leave the flags unchanged.
- R10: A write to address 2 with `wide` = 1 loads `wdata[15:8]` into the high byte and `wdata[7:0]` into the low byte in one cycle. A read of address 2 with `wide` = 1 returns {high, low}. Byte accesses use address 2 for the high byte and address 3 for the low byte, in `wdata[7:0]` and `rdata[7:0]`.
- R11: A count register write in the same cycle as a count event takes priority, and that event is not counted.
- R12: `irq` equals (flag bit 0 AND control bit 5) OR (flag bit 1 AND control bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator input (event or gate) |
| tick_en | input | 1 | Prescaled clock enable used in gated mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for fast flag clear) |
| addr | input | 2 | Register address: 0 control, 1 flags, 2 count high, 3 count low |
| wide | input | 1 | 16-bit count access at address 2 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr and wide |
| irq | output | 1 | Interrupt request |

## Verification
Every piece of internal state is visible at the ports. A wrong synchroniser or edge history shows as a count that is off by one, or a count that moves on the wrong edge, at the first read after three clock edges. A broken carry or write priority shows in the 16-bit read value on the same cycle the byte wraps or is written. A wrong flag state reaches `irq` combinationally, so it is exposed in the cycle it occurs as soon as its enable is set. The sweeps therefore read back the count and flags after every stimulus group, covering both polarities, both modes and both counter arrangements.

// File: rtl/pa_pkg.sv
// Package: shared register addresses and control-register layout for the
// pulse accumulator. Assumes a byte-wide control register.
package pa_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_FLAG = 2'd1,
        ADR_CNTH = 2'd2,
        ADR_CNTL = 2'd3
    } pa_addr_e;

    typedef struct packed {
        logic [1:0] spare;
        logic       ie_edge;   // bit 5
        logic       ie_ovf;    // bit 4
        logic       fast_clr;  // bit 3
        logic       pol;       // bit 2
        logic       gated;     // bit 1
        logic       chain;     // bit 0
    } pa_ctrl_t;

    localparam int FLAG_EDGE = 0;
    localparam int FLAG_OVF  = 1;
endpackage

// File: rtl/pa_sync_edge.sv
// Module: synchronises the accumulator input and turns it into count events
// and flag events. Assumes pol and gated change only while the input is idle.
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic gated,
    input  logic tick_en,
    output logic count_evt,
    output logic flag_evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level, act_now, act_prev, lead, trail;

    // Shift the raw pin through the synchroniser chain and keep history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Derive active-level transitions and the mode-selected events.
    always_comb begin
        level     = sync_q[STAGES-1];
        act_now   = (level == pol);
        act_prev  = (prev_q == pol);
        lead      = act_now & ~act_prev;
        trail     = act_prev & ~act_now;
        count_evt = gated ? (tick_en & act_now) : lead;
        flag_evt  = gated ? trail : lead;
    end

    // R2: an edge event in event mode never lasts two cycles.
    p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gated && count_evt && $stable(gated) && $stable(pol)) |=> !count_evt);
endmodule

// File: rtl/pa_counter.sv
// Module: two byte counters, chained or independent, with write priority
// over counting. Assumes at most one count event per cycle.
module pa_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chain,
    input  logic         evt,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wd_hi,
    input  logic [W-1:0] wd_lo,
    output logic [W-1:0] cnt_hi,
    output logic [W-1:0] cnt_lo,
    output logic         hi_wrap
);
    logic step, hi_step, lo_full, hi_full;

    // Decide which bytes advance this cycle.
    always_comb begin
        lo_full = &cnt_lo;
        hi_full = &cnt_hi;
        step    = evt & ~(wr_hi | wr_lo);
        hi_step = step & (chain ? lo_full : 1'b1);
        hi_wrap = hi_step & hi_full;
    end

    // Load or advance the two byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            if (wr_lo)     cnt_lo <= wd_lo;
            else if (step) cnt_lo <= cnt_lo + 1'b1;
            if (wr_hi)        cnt_hi <= wd_hi;
            else if (hi_step) cnt_hi <= cnt_hi + 1'b1;
        end
    end

    // R11: a write lands exactly, whatever the count event.
    p_wr_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_lo == $past(wd_lo));
    // R4: a chained low-byte wrap carries into the high byte.
    p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && chain && lo_full && !wr_hi && !wr_lo) |=>
            (cnt_hi == W'($past(cnt_hi) + 1'b1)) && (cnt_lo == '0));
endmodule

// File: rtl/pa_flags.sv
// Module: overflow and input-edge flags with write-one-to-clear and an
// interrupt request. Assumes set requests win over clear requests.
module pa_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_edge,
    input  logic       set_ovf,
    input  logic [1:0] clr_mask,
    input  logic [1:0] irq_en,
    output logic [1:0] flags,
    output logic       irq
);
    // Update the flags: clear requested bits, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 2'b00;
        else        flags <= (flags & ~clr_mask) | {set_ovf, set_edge};
    end

    // Combine enabled flags into one request.
    always_comb irq = |(flags & irq_en);

    // R8: a set in the same cycle as a clear leaves the flag set.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf |=> flags[1]);
    // R8: a clear with no set empties the edge flag.
    p_clear_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[0] && !set_edge) |=> !flags[0]);
    // R8: a zero clear bit keeps the overflow flag.
    p_hold_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr_mask[1]) |=> flags[1]);
    // R6: the overflow flag only rises after a set request.
    p_ovf_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(set_ovf));
endmodule

// File: rtl/pulse_accum.sv
// Module: top of the pulse accumulator. Holds the control register, decodes
// the strobe bus and connects synchroniser, counters and flags.
// Assumes strobes are single-cycle and addr/wide are valid with them.
module pulse_accum #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_in,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic        wide,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    import pa_pkg::*;
    localparam int W  = BYTE_W;
    localparam int DW = 2 * W;

    pa_ctrl_t    ctrl_q;
    logic        count_evt, flag_evt, hi_wrap;
    logic        wr_hi, wr_lo, cnt_access;
    logic [W-1:0] wd_hi, cnt_hi, cnt_lo;
    logic [1:0]  clr_mask, flags;
    pa_addr_e    adr;

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr_en && adr == ADR_CTRL)  ctrl_q <= pa_ctrl_t'(wdata[W-1:0]);
    end

    // Decode count writes, wide access and flag clears.
    always_comb begin
        adr        = pa_addr_e'(addr);
        cnt_access = (wr_en | rd_en) & ((adr == ADR_CNTH) | (adr == ADR_CNTL));
        wr_hi      = wr_en & (adr == ADR_CNTH);
        wr_lo      = wr_en & ((adr == ADR_CNTL) | ((adr == ADR_CNTH) & wide));
        wd_hi      = ((adr == ADR_CNTH) && wide) ? wdata[DW-1:W] : wdata[W-1:0];
        clr_mask   = ((wr_en && adr == ADR_FLAG) ? wdata[1:0] : 2'b00)
                   | ((ctrl_q.fast_clr && cnt_access) ? 2'b11 : 2'b00);
    end

    // Return the addressed register.
    always_comb begin
        unique case (adr)
            ADR_CTRL: rdata = {{W{1'b0}}, ctrl_q};
            ADR_FLAG: rdata = {{(DW-2){1'b0}}, flags};
            ADR_CNTH: rdata = wide ? {cnt_hi, cnt_lo} : {{W{1'b0}}, cnt_hi};
            default:  rdata = {{W{1'b0}}, cnt_lo};
        endcase
    end

    pa_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin(pin_in), .pol(ctrl_q.pol),
        .gated(ctrl_q.gated), .tick_en(tick_en),
        .count_evt(count_evt), .flag_evt(flag_evt)
    );

    pa_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .chain(ctrl_q.chain), .evt(count_evt),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wd_hi(wd_hi), .wd_lo(wdata[W-1:0]),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .hi_wrap(hi_wrap)
    );

    pa_flags flags_i (
        .clk(clk), .rst_n(rst_n), .set_edge(flag_evt), .set_ovf(hi_wrap),
        .clr_mask(clr_mask), .irq_en({ctrl_q.ie_ovf, ctrl_q.ie_edge}),
        .flags(flags), .irq(irq)
    );

    // R9: a count access in fast-clear mode empties the flags.
    p_fast_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.fast_clr && cnt_access && !flag_evt && !hi_wrap) |=> flags == 2'b00);
    // R12: with both enables off no request is raised.
    p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ie_ovf && !ctrl_q.ie_edge) |-> !irq);
endmodule

// File: tb/pulse_accum_tb_top.sv
// Bench: sweeps modes, polarities and pulse counts; expected values are
// computed from the requirements.
module pulse_accum_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, wide = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq;
    int          errs = 0, checks = 0;
    logic [15:0] v;

    always #10 clk = ~clk;

    pulse_accum dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick_en(tick_en),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wide(wide),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic w);
        @(negedge clk); addr = a; wdata = d; wide = w; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; wide = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic w, output logic [15:0] d);
        @(negedge clk); addr = a; wide = w; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; wide = 1'b0;
    endtask

    task automatic settle(); repeat (4) @(negedge clk); endtask

    // Put the pin at its idle level, then program ctrl and zero count and flags.
    task automatic setup(input logic [7:0] c, input logic idle);
        @(negedge clk); pin_in = idle; settle();
        bus_wr(2'd0, {8'h00, c}, 1'b0);
        bus_wr(2'd2, 16'h0000, 1'b1);
        bus_wr(2'd1, 16'h0003, 1'b0);
    endtask

    task automatic pulses(input int n, input logic pol);
        for (int i = 0; i < n; i++) begin
            pin_in = pol; settle();
            pin_in = ~pol; settle();
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_rd(2'd0, 1'b0, v); chk("R1 ctrl", v, 16'h0000);
        bus_rd(2'd1, 1'b0, v); chk("R1 flags", v, 16'h0000);
        bus_rd(2'd2, 1'b1, v); chk("R1 count", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 R7 event mode, both polarities, several pulse counts
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                n = (k == 0) ? 0 : (k * k * 3 - 1);
                setup(p ? 8'h05 : 8'h01, ~p[0]);
                pulses(n, p[0]);
                bus_rd(2'd2, 1'b1, v); chk($sformatf("R2 events pol=%0d n=%0d", p, n), v, 16'(n));
                bus_rd(2'd1, 1'b0, v); chk("R7 event edge flag", v, (n > 0) ? 16'h0001 : 16'h0000);
            end
        end

        // R3 R7 gated mode, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int n = 1; n < 12; n += 5) begin
                setup(p ? 8'h07 : 8'h03, ~p[0]);
                @(negedge clk); pin_in = p[0]; settle();
                bus_rd(2'd1, 1'b0, v); chk("R7 leading gate edge no flag", v, 16'h0000);
                ticks(n);
                @(negedge clk); pin_in = ~p[0]; settle();
                ticks(3);
                bus_rd(2'd2, 1'b1, v); chk($sformatf("R3 gated pol=%0d n=%0d", p, n), v, 16'(n));
                bus_rd(2'd1, 1'b0, v); chk("R7 trailing gate flag", v, 16'h0001);
            end
        end

        // R4 carry across bytes; R10 byte reads
        setup(8'h05, 1'b0);
        bus_wr(2'd2, 16'h00FE, 1'b1);
        pulses(3, 1'b1);
        bus_rd(2'd2, 1'b1, v); chk("R4 carry", v, 16'h0101);
        bus_rd(2'd2, 1'b0, v); chk("R10 hi byte", v, 16'h0001);
        bus_rd(2'd3, 1'b0, v); chk("R10 lo byte", v, 16'h0001);

        // R6 overflow only on the high-byte wrap
        setup(8'h05, 1'b0);
        bus_wr(2'd2, 16'hFFFD, 1'b1);
        pulses(2, 1'b1);
        bus_rd(2'd1, 1'b0, v); chk("R6 no ovf before wrap", v & 16'h0002, 16'h0000);
        pulses(1, 1'b1);
        bus_rd(2'd2, 1'b1, v); chk("R6 wrapped count", v, 16'h0000);
        bus_rd(2'd1, 1'b0, v); chk("R6 ovf set", v, 16'h0003);

        // R8 write-one-to-clear
        bus_wr(2'd1, 16'h0000, 1'b0);
        bus_rd(2'd1, 1'b0, v); chk("R8 zero write keeps", v, 16'h0003);
        bus_wr(2'd1, 16'h0001, 1'b0);
        bus_rd(2'd1, 1'b0, v); chk("R8 clear edge only", v, 16'h0002);
        bus_wr(2'd1, 16'h0002, 1'b0);
        bus_rd(2'd1, 1'b0, v); chk("R8 clear ovf", v, 16'h0000);

        // R5 independent bytes
        setup(8'h04, 1'b0);
        bus_wr(2'd2, 16'h00FE, 1'b0);
        bus_wr(2'd3, 16'h0010, 1'b0);
        pulses(3, 1'b1);
        bus_rd(2'd2, 1'b1, v); chk("R5 separate bytes", v, 16'h0113);
        bus_rd(2'd1, 1'b0, v); chk("R5 R6 hi wrap flag", v, 16'h0003);

        // R8 set wins over clear in the same cycle
        setup(8'h07, 1'b0);
        @(negedge clk); pin_in = 1'b1; settle();
        bus_wr(2'd2, 16'hFFFF, 1'b1);
        @(negedge clk); tick_en = 1'b1; addr = 2'd1; wdata = 16'h0002; wr_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        bus_rd(2'd1, 1'b0, v); chk("R8 set wins", v, 16'h0002);
        bus_rd(2'd2, 1'b1, v); chk("R8 count wrapped", v, 16'h0000);

        // R11 write beats a count event (pin still active)
        @(negedge clk); tick_en = 1'b1; addr = 2'd3; wdata = 16'h0040; wr_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        bus_rd(2'd2, 1'b1, v); chk("R11 byte write prio", v, 16'h0040);
        @(negedge clk); tick_en = 1'b1; addr = 2'd2; wdata = 16'h1234; wide = 1'b1; wr_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0; wide = 1'b0;
        bus_rd(2'd2, 1'b1, v); chk("R11 R10 wide write prio", v, 16'h1234);
        @(negedge clk); pin_in = 1'b0; settle();

        // R9 fast clear
        setup(8'h05, 1'b0);
        bus_wr(2'd2, 16'hFFFF, 1'b1);
        pulses(1, 1'b1);
        bus_rd(2'd3, 1'b0, v);
        bus_rd(2'd1, 1'b0, v); chk("R9 no fast clear", v, 16'h0003);
        bus_wr(2'd0, 16'h000D, 1'b0);
        bus_rd(2'd2, 1'b0, v);
        bus_rd(2'd1, 1'b0, v); chk("R9 read clears", v, 16'h0000);
        pulses(1, 1'b1);
        bus_wr(2'd3, 16'h0007, 1'b0);
        bus_rd(2'd1, 1'b0, v); chk("R9 write clears", v, 16'h0000);

        // R12 interrupt enables
        setup(8'h05, 1'b0);
        pulses(1, 1'b1);
        @(negedge clk); chk("R12 masked", {15'd0, irq}, 16'h0000);
        bus_wr(2'd0, 16'h0025, 1'b0);
        @(negedge clk); chk("R12 edge irq", {15'd0, irq}, 16'h0001);
        bus_wr(2'd1, 16'h0001, 1'b0);
        @(negedge clk); chk("R12 cleared", {15'd0, irq}, 16'h0000);
        bus_wr(2'd0, 16'h0015, 1'b0);
        bus_wr(2'd2, 16'hFFFF, 1'b1);
        pulses(1, 1'b1);
        @(negedge clk); chk("R12 ovf irq", {15'd0, irq}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule